// File: doc/BRIEF.md
# Nine-bit symbol error patcher

This block repairs one 512-byte sector after an outside Reed-Solomon decoder has located its faults. The sector sits in a byte buffer inside the block. Software or a loader fills that buffer through a simple byte port, then pulses `start` and presents the decoder's verdict: an error flag, an uncorrectable flag, an error count and four slots. Each slot holds a symbol index and a 9-bit error mask.

Each symbol is 9 bits wide, so a reported fault can cover parts of two adjacent bytes. For every valid slot the engine turns the 1-based symbol index into a byte position and aligns the mask to the bit offset of that symbol. It then performs a read, XOR and write-back on the first byte and, where one exists, on the next byte. The slots are processed from the highest one in use down to slot 0. A one-cycle `done` pulse closes the run. The corrected sector is then read back through the same byte port.

Top module: `sym_patch`

## Requirements
- R1: While idle, a write (`buf_we`=1) stores `buf_wdata` at `buf_addr`, and `buf_rdata` shows the byte at the `buf_addr` presented one clock earlier.
- R2: For a slot with 1-based index i, let d = i-1 and p = d + (d>>3). The 9-bit mask is shifted left by d[2:0]. Bits 7:0 of the shifted value are XORed into byte p and bits 15:8 into byte p+1.
- R3: A slot whose index is 0, or whose position p is 512 or more, changes no byte.
- R4: When p is 511, only byte 511 is modified. The bits that would fall past the end of the sector are dropped.
- R5: When `uncor_flag` is 1 or `err_flag` is 0 at start, the buffer is left unchanged and `done` still pulses.
- R6: An error count c from 1 to 4 applies slots c-1 down to 0, and slots at c and above have no effect. A count of 0 or 5 to 7 applies nothing. Slot k uses `idx_bus[k*10 +: 10]` and `mask_bus[k*9 +: 9]`.
- R7: After reset, `busy` and `done` are 0. `busy` rises on the clock edge that takes `start` while idle. `done` is high for exactly one cycle, the last cycle of `busy`.
- R8: Byte writes presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Byte write strike (idle only) |
| buf_addr | input | 9 | Byte address for write and read |
| buf_wdata | input | 8 | Byte to write |
| buf_rdata | output | 8 | Registered read data |
| start | input | 1 | Begin a correction run; status inputs sampled with it |
| err_flag | input | 1 | Decoder saw errors |
| uncor_flag | input | 1 | Decoder gave up |
| err_cnt | input | 3 | Number of slots in use |
| idx_bus | input | 40 | Four 10-bit 1-based symbol indices |
| mask_bus | input | 36 | Four 9-bit error masks |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random sectors are paired with random counts, random indices that run past the sector end and random masks. The readback is compared with a bench model of the byte mapping. This distinguishes wrong shift amounts, wrong position arithmetic and a missing second byte. Directed runs then cover several cases: index 456, which lands on byte 511; indices 0 and 457, which must be skipped; a run with the uncorrectable flag set, one with the error flag clear, and counts of 0 and 7. Those runs separate a bounds check that is wrong from a gating check that is wrong. A run with count 1 and live data in slots 1 to 3 shows that unused slots are left alone. A write issued mid-run shows that the byte port is locked while busy.

// File: rtl/sym_patch.sv
module sym_patch #(
  parameter int SECTOR = 512,
  parameter int SLOTS  = 4,
  parameter int IDXW   = 10,
  parameter int MASKW  = 9,
  parameter int AW     = $clog2(SECTOR),
  parameter int SLW    = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   buf_we,
  input  logic [AW-1:0]          buf_addr,
  input  logic [7:0]             buf_wdata,
  output logic [7:0]             buf_rdata,
  input  logic                   start,
  input  logic                   err_flag,
  input  logic                   uncor_flag,
  input  logic [2:0]             err_cnt,
  input  logic [SLOTS*IDXW-1:0]  idx_bus,
  input  logic [SLOTS*MASKW-1:0] mask_bus,
  output logic                   busy,
  output logic                   done
);
  localparam int SHW = MASKW + 7;

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_RD0, S_WR0, S_RD1, S_WR1, S_DONE} st_t;
  st_t state;

  logic [7:0]             mem [SECTOR];
  logic [7:0]             rq;
  logic [SLOTS*IDXW-1:0]  idx_q;
  logic [SLOTS*MASKW-1:0] mask_q;
  logic [SLW-1:0]         sl;
  logic [AW-1:0]          pos_q;
  logic [15:0]            shm_q;

  logic [IDXW-1:0]  cur_idx, d;
  logic [MASKW-1:0] cur_mask;
  logic [IDXW:0]    pos_c;
  logic [SHW-1:0]   shm_c;
  logic             skip, act, lo_wr, hi_wr;
  logic [AW-1:0]    raddr;

  assign cur_idx  = idx_q[sl*IDXW +: IDXW];
  assign cur_mask = mask_q[sl*MASKW +: MASKW];
  assign d        = cur_idx - 1'b1;
  assign pos_c    = {1'b0, d} + {4'b0, d[IDXW-1:3]};
  assign shm_c    = {7'b0, cur_mask} << d[2:0];
  assign skip     = (cur_idx == '0) || (pos_c >= (IDXW+1)'(SECTOR));
  assign act      = err_flag && !uncor_flag && (err_cnt != 3'd0) && (err_cnt <= 3'(SLOTS));
  assign lo_wr    = state == S_WR0;
  assign hi_wr    = state == S_WR1;
  assign busy     = state != S_IDLE;
  assign done     = state == S_DONE;
  assign buf_rdata = rq;
  assign raddr    = (state == S_RD0) ? pos_q : (state == S_RD1) ? pos_q + 1'b1 : buf_addr;

  always_ff @(posedge clk) begin
    rq <= mem[raddr];
    if (lo_wr)
      mem[pos_q] <= rq ^ shm_q[7:0];
    else if (hi_wr)
      mem[pos_q + 1'b1] <= rq ^ shm_q[15:8];
    else if (state == S_IDLE && buf_we)
      mem[buf_addr] <= buf_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sl     <= '0;
      idx_q  <= '0;
      mask_q <= '0;
      pos_q  <= '0;
      shm_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx_q  <= idx_bus;
          mask_q <= mask_bus;
          sl     <= SLW'(err_cnt - 3'd1);
          state  <= act ? S_PICK : S_DONE;
        end
        S_PICK: begin
          pos_q <= pos_c[AW-1:0];
          shm_q <= 16'(shm_c);
          if (!skip)         state <= S_RD0;
          else if (sl == '0) state <= S_DONE;
          else               sl <= sl - 1'b1;
        end
        S_RD0: state <= S_WR0;
        S_WR0: begin
          if (pos_q != AW'(SECTOR-1)) state <= S_RD1;
          else if (sl == '0)          state <= S_DONE;
          else begin
            sl    <= sl - 1'b1;
            state <= S_PICK;
          end
        end
        S_RD1: state <= S_WR1;
        S_WR1: begin
          if (sl == '0) state <= S_DONE;
          else begin
            sl    <= sl - 1'b1;
            state <= S_PICK;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sym_patch_chk.sv
module sym_patch_chk #(parameter int AW = 9, parameter int SECTOR = 512) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          err_flag,
  input logic          uncor_flag,
  input logic          busy,
  input logic          done,
  input logic          hi_wr,
  input logic [AW-1:0] pos_q
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  p_last_byte_r4: assert property (@(posedge clk) disable iff (!rst_n) hi_wr |-> pos_q != AW'(SECTOR-1));
  p_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (uncor_flag || !err_flag)) |=> done);
endmodule

bind sym_patch sym_patch_chk #(.AW(AW), .SECTOR(SECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .err_flag(err_flag), .uncor_flag(uncor_flag),
  .busy(busy), .done(done), .hi_wr(hi_wr), .pos_q(pos_q)
);

// File: tb/sym_patch_tb.sv
module sym_patch_tb;
  logic clk = 0, rst_n = 0;
  logic buf_we = 0, start = 0, err_flag = 0, uncor_flag = 0;
  logic [8:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0, buf_rdata;
  logic [2:0] err_cnt = 0;
  logic [39:0] idx_bus = 0;
  logic [35:0] mask_bus = 0;
  logic busy, done;

  int total = 0, bad = 0;
  logic [7:0] model [512];

  always #4 clk = ~clk;

  sym_patch u_dut (.clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .start(start), .err_flag(err_flag),
    .uncor_flag(uncor_flag), .err_cnt(err_cnt), .idx_bus(idx_bus), .mask_bus(mask_bus),
    .busy(busy), .done(done));

  function automatic void fix(int idx, int mask);
    int dd, p, m;
    if (idx == 0) return;
    dd = idx - 1;
    p = dd + (dd >> 3);
    if (p >= 512) return;
    m = mask << (dd & 7);
    model[p] ^= 8'(m);
    if (p < 511) model[p+1] ^= 8'(m >> 8);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_rand();
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      buf_we = 1; buf_addr = 9'(a); buf_wdata = 8'($urandom);
      model[a] = buf_wdata;
    end
    @(negedge clk);
    buf_we = 0;
  endtask

  task automatic compare(string req);
    int errs = 0, fa = -1, fv = 0;
    for (int a = 0; a < 512; a++) begin
      buf_addr = 9'(a);
      @(negedge clk);
      if (buf_rdata != model[a]) begin
        errs++;
        if (fa < 0) begin fa = a; fv = buf_rdata; end
      end
    end
    if (errs != 0) check(req, fv, model[fa]);
    else check(req, 0, 0);
  endtask

  task automatic run(bit ef, bit uf, int cnt, int idx[4], int msk[4], bit poke, string req);
    int dn = 0, cyc = 0;
    @(negedge clk);
    err_flag = ef; uncor_flag = uf; err_cnt = 3'(cnt);
    for (int k = 0; k < 4; k++) begin
      idx_bus[k*10 +: 10] = 10'(idx[k]);
      mask_bus[k*9 +: 9] = 9'(msk[k]);
    end
    start = 1;
    @(negedge clk);
    start = 0;
    check("R7 busy after start", busy, 1);
    if (poke) begin
      buf_we = 1; buf_addr = 9'd0; buf_wdata = ~model[0];
    end
    while (busy && cyc < 100) begin
      if (done) dn++;
      @(negedge clk);
      buf_we = 0;
      cyc++;
    end
    buf_we = 0;
    check("R7 single done pulse", dn, 1);
    if (ef && !uf && cnt >= 1 && cnt <= 4)
      for (int k = cnt - 1; k >= 0; k--) fix(idx[k], msk[k]);
    compare(req);
  endtask

  initial begin
    int i4[4], m4[4];
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R7 reset busy", busy, 0);
    check("R7 reset done", done, 0);
    rst_n = 1;
    load_rand();
    compare("R1 write/read");

    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < 4; k++) begin
        i4[k] = $urandom_range(0, 470);
        m4[k] = $urandom_range(1, 511);
      end
      run(($urandom_range(0, 9) != 0), ($urandom_range(0, 9) == 0),
          $urandom_range(0, 7), i4, m4, 0, "R2 random patch");
    end

    i4 = '{456, 1, 457, 0}; m4 = '{9'h1ff, 9'h1ff, 9'h1ff, 9'h1ff};
    run(1, 0, 4, i4, m4, 0, "R4 last byte / R3 skip");
    i4 = '{8, 9, 16, 17}; m4 = '{9'h101, 9'h0ff, 9'h180, 9'h003};
    run(1, 0, 4, i4, m4, 0, "R2 straddle");
    i4 = '{10, 20, 30, 40}; m4 = '{9'h1ff, 9'h1ff, 9'h1ff, 9'h1ff};
    run(1, 1, 4, i4, m4, 0, "R5 uncorrectable");
    run(0, 0, 4, i4, m4, 0, "R5 no error flag");
    run(1, 0, 0, i4, m4, 0, "R6 count zero");
    run(1, 0, 7, i4, m4, 0, "R6 count seven");
    run(1, 0, 1, i4, m4, 0, "R6 count one");
    run(1, 0, 4, i4, m4, 1, "R8 write while busy");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule